// File: doc/BRIEF.md
# Vectored interrupt controller core

This block gathers twenty-six interrupt request lines into a sticky pending register and turns them into the processor's two interrupt inputs: a normal request (`irq`) and a fast request (`fiq`). Each source has its own mask bit, and one global mask bit blocks both outputs. A mode bit per source sends that source to the fast line (1) or to the normal line (0). Software ends an interrupt by writing ones to one of two write-one-to-clear registers. The pending register itself cannot be written.

The block does not arbitrate. It presents the unmasked pending normal-line sources on `irq_cand`. A separate priority arbiter returns the winning index on `win_idx` and qualifies it with `win_valid`. When the processor fetches its normal-interrupt entry word (`vec_fetch`), the block can replace the memory word with a computed branch opcode that jumps to the winner's vector slot. The service-pending register shows the winner as a one-hot value. The service state machine has two states:
- `SVC_IDLE`: the register follows the arbiter.
- `SVC_HOLD`: entered on an accepted entry fetch (transition *take*). The register is frozen on the captured source until software writes the normal clear register (transition *release*).

Register selects on `reg_addr`:

| Select | Register | Access |
|---|---|---|
| 0 | CTRL: bit0 vector enable, bit1 normal-line enable, bit2 fast-line enable | read/write |
| 1 | PEND | read-only |
| 2 | MODE | read/write |
| 3 | MASK: bits 25:0 per source, bit 26 global | read/write |
| 4 | SVC, the service-pending register | read-only |
| 5 | ICLR | write-one-to-clear |
| 6 | FCLR | write-one-to-clear |

Top module: `vic_core`

## Requirements
- R1: After reset, `irq` and `fiq` are 0, CTRL reads 0, PEND reads 0, SVC reads 0 and MASK reads 0x07FFFFFF (every source and the global bit masked).
- R2: A source request that is high at a rising edge sets its PEND bit at that edge, even when the source is masked. The bit stays set until it is cleared.
- R3: While MASK bit 26 is 1, `irq` and `fiq` stay 0, but PEND bits still latch.
- R4: `irq` is 1 exactly when CTRL bit1 is 1, the global mask is 0, and some pending, unmasked source has mode 0. `fiq` is 1 under the same terms with CTRL bit2 and mode 1.
- R5: Writing 1 to a bit of ICLR (select 5) or FCLR (select 6) clears that PEND bit. Writing 0 leaves the bit unchanged. A request in the same cycle as a clear keeps the bit set. Both clear registers read 0.
- R6: Writes to PEND (select 1) have no effect.
- R7: With `vec_fetch` high, CTRL bits 0 and 1 set, `win_valid` high and the state machine idle, `instr_rdata` is 0xEA000000 + ((V − 0x20) >> 2). Here V = 0x20 + (i/6)·0x20 + (i%6)·4 and i is `win_idx`. Otherwise `instr_rdata` equals `mem_rdata`.
- R8: `irq_cand` never contains a source whose mode bit is 1, so fast-line sources never receive a vectored branch.
- R9: In `SVC_IDLE`, SVC is the one-hot of `win_idx` when `win_valid` is high, and 0 otherwise. An entry fetch that is accepted with CTRL bit1 set captures that index and moves to `SVC_HOLD`. SVC then stays frozen until a write to ICLR returns the machine to `SVC_IDLE`.
- R10: While in `SVC_HOLD`, an entry fetch returns `mem_rdata` and no branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_req | input | 26 | Interrupt request per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_cand | output | 26 | Unmasked pending normal-line sources, sent to the arbiter |
| win_valid | input | 1 | Arbiter has a winner |
| win_idx | input | 5 | Index of the winning source |
| vec_fetch | input | 1 | Processor is fetching the normal-interrupt entry word |
| mem_rdata | input | 32 | Memory word for that fetch |
| instr_rdata | output | 32 | Word returned to the processor |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
Pending bits, mask, mode and control take effect at the rising edge that samples the request or write. `irq`, `fiq`, `irq_cand` and the register read data follow without a further register, so they are due one edge after the stimulus. `instr_rdata` and the idle SVC value are combinational and are due in the same cycle as `vec_fetch` or the arbiter's answer. The freeze of SVC begins at the edge that samples the fetch. The bench applies every stimulus just after a falling edge and reads outputs 1 ns later, so each result is observed either in the same low phase or one rising edge later, as counted above.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC = 26;
    localparam int IW   = $clog2(NSRC);
    localparam int DW   = 32;
    localparam int AW   = 3;
    localparam int GRP  = 6;

    localparam logic [31:0] SLOT_FIRST  = 32'h0000_0020;
    localparam logic [31:0] SLOT_STRIDE = 32'h0000_0020;
    localparam logic [31:0] SLOT_BYTES  = 32'h0000_0004;
    localparam logic [31:0] ENTRY_ADDR  = 32'h0000_0018;
    localparam logic [31:0] PC_AHEAD    = 32'h0000_0008;
    localparam logic [31:0] BRANCH_BASE = 32'hEA00_0000;

    typedef enum logic [AW-1:0] {
        SEL_CTRL = 3'd0,
        SEL_PEND = 3'd1,
        SEL_MODE = 3'd2,
        SEL_MASK = 3'd3,
        SEL_SVC  = 3'd4,
        SEL_ICLR = 3'd5,
        SEL_FCLR = 3'd6
    } reg_sel_e;

    typedef enum logic [0:0] {
        SVC_IDLE = 1'b0,
        SVC_HOLD = 1'b1
    } svc_state_e;

    typedef struct packed {
        logic fiq_en;
        logic irq_en;
        logic vec_en;
    } ctrl_t;
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
    parameter int NSRC = vic_pkg::NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] clr,
    input  logic            mode_we,
    input  logic            mask_we,
    input  logic [NSRC:0]   wdata,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] mode,
    output logic [NSRC:0]   mask,
    output logic [NSRC-1:0] irq_cand,
    output logic [NSRC-1:0] fiq_cand
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            mode <= '0;
            mask <= '1;
        end else begin
            pend <= (pend & ~clr) | req;
            if (mode_we) mode <= wdata[NSRC-1:0];
            if (mask_we) mask <= wdata;
        end
    end

    always_comb begin
        irq_cand = pend & ~mask[NSRC-1:0] & ~mode;
        fiq_cand = pend & ~mask[NSRC-1:0] &  mode;
    end
endmodule

// File: rtl/vic_svc_fsm.sv
module vic_svc_fsm #(
    parameter int NSRC = vic_pkg::NSRC,
    parameter int IW   = vic_pkg::IW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic                 release_req,
    input  logic                 win_valid,
    input  logic [IW-1:0]        win_idx,
    output vic_pkg::svc_state_e  state,
    output logic [NSRC-1:0]      svc_vec
);
    import vic_pkg::*;

    svc_state_e  nxt;
    logic [IW-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= SVC_IDLE;
            held_q <= '0;
        end else begin
            state <= nxt;
            if (state == SVC_IDLE && take) held_q <= win_idx;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SVC_IDLE: if (take)        nxt = SVC_HOLD;
            SVC_HOLD: if (release_req) nxt = SVC_IDLE;
            default:                   nxt = SVC_IDLE;
        endcase
    end

    always_comb begin
        svc_vec = '0;
        unique case (state)
            SVC_IDLE: if (win_valid && (int'(win_idx) < NSRC)) svc_vec[win_idx] = 1'b1;
            SVC_HOLD: if (int'(held_q) < NSRC)                 svc_vec[held_q]  = 1'b1;
            default:  svc_vec = '0;
        endcase
    end
endmodule

// File: rtl/vic_vec_gen.sv
module vic_vec_gen #(
    parameter int          IW          = vic_pkg::IW,
    parameter int          GRP         = vic_pkg::GRP,
    parameter logic [31:0] SLOT_FIRST  = vic_pkg::SLOT_FIRST,
    parameter logic [31:0] SLOT_STRIDE = vic_pkg::SLOT_STRIDE,
    parameter logic [31:0] SLOT_BYTES  = vic_pkg::SLOT_BYTES,
    parameter logic [31:0] ENTRY_ADDR  = vic_pkg::ENTRY_ADDR,
    parameter logic [31:0] PC_AHEAD    = vic_pkg::PC_AHEAD,
    parameter logic [31:0] BRANCH_BASE = vic_pkg::BRANCH_BASE
) (
    input  logic          drive,
    input  logic [IW-1:0] win_idx,
    input  logic [31:0]   mem_rdata,
    output logic [31:0]   instr_rdata
);
    localparam int TAB = 1 << IW;

    logic [31:0] op_tab [TAB];

    for (genvar g = 0; g < TAB; g++) begin : g_slot
        localparam logic [31:0] SLOT_ADDR = SLOT_FIRST
                                          + 32'(g / GRP) * SLOT_STRIDE
                                          + 32'(g % GRP) * SLOT_BYTES;
        assign op_tab[g] = BRANCH_BASE + ((SLOT_ADDR - ENTRY_ADDR - PC_AHEAD) >> 2);
    end

    always_comb begin
        instr_rdata = drive ? op_tab[win_idx] : mem_rdata;
    end
endmodule

// File: rtl/vic_core.sv
module vic_core #(
    parameter int NSRC = vic_pkg::NSRC,
    parameter int IW   = vic_pkg::IW,
    parameter int DW   = vic_pkg::DW,
    parameter int AW   = vic_pkg::AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [NSRC-1:0] irq_cand,
    input  logic            win_valid,
    input  logic [IW-1:0]   win_idx,
    input  logic            vec_fetch,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   instr_rdata,
    output logic            irq,
    output logic            fiq
);
    import vic_pkg::*;

    ctrl_t           ctrl_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mode_q;
    logic [NSRC:0]   mask_q;
    logic [NSRC-1:0] fiq_cand;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] svc_vec;
    svc_state_e      svc_state;
    logic            iclr_wr;
    logic            fclr_wr;
    logic            take;
    logic            drive_vec;

    always_comb begin
        iclr_wr   = reg_wr && (reg_addr == SEL_ICLR);
        fclr_wr   = reg_wr && (reg_addr == SEL_FCLR);
        clr_vec   = (iclr_wr || fclr_wr) ? reg_wdata[NSRC-1:0] : '0;
        take      = vec_fetch && ctrl_q.irq_en && win_valid && (svc_state == SVC_IDLE);
        drive_vec = take && ctrl_q.vec_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && reg_addr == SEL_CTRL) begin
            ctrl_q <= ctrl_t'(reg_wdata[2:0]);
        end
    end

    vic_src_bank #(.NSRC(NSRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (src_req),
        .clr      (clr_vec),
        .mode_we  (reg_wr && reg_addr == SEL_MODE),
        .mask_we  (reg_wr && reg_addr == SEL_MASK),
        .wdata    (reg_wdata[NSRC:0]),
        .pend     (pend_q),
        .mode     (mode_q),
        .mask     (mask_q),
        .irq_cand (irq_cand),
        .fiq_cand (fiq_cand)
    );

    vic_svc_fsm #(.NSRC(NSRC), .IW(IW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .release_req (iclr_wr),
        .win_valid   (win_valid),
        .win_idx     (win_idx),
        .state       (svc_state),
        .svc_vec     (svc_vec)
    );

    vic_vec_gen #(.IW(IW)) u_vec (
        .drive       (drive_vec),
        .win_idx     (win_idx),
        .mem_rdata   (mem_rdata),
        .instr_rdata (instr_rdata)
    );

    always_comb begin
        irq = ctrl_q.irq_en && !mask_q[NSRC] && (|irq_cand);
        fiq = ctrl_q.fiq_en && !mask_q[NSRC] && (|fiq_cand);
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_CTRL: reg_rdata[2:0]      = ctrl_q;
            SEL_PEND: reg_rdata[NSRC-1:0] = pend_q;
            SEL_MODE: reg_rdata[NSRC-1:0] = mode_q;
            SEL_MASK: reg_rdata[NSRC:0]   = mask_q;
            SEL_SVC:  reg_rdata[NSRC-1:0] = svc_vec;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
    parameter int NSRC = vic_pkg::NSRC
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_req,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] mode,
    input logic            gmask,
    input logic            irq,
    input logic            fiq,
    input logic [NSRC-1:0] svc,
    input logic            hold,
    input logic            iclr_wr
);
    // R2
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(src_req) & ~pend) == '0));

    // R3
    gmask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gmask |-> (!irq && !fiq));

    // R4
    fiq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq |-> (|(pend & mode)));

    // R4
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(pend & ~mode)));

    // R9
    svc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc));

    // R9
    svc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !iclr_wr) |=> $stable(svc));
endmodule

bind vic_core vic_core_chk #(.NSRC(NSRC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_req (src_req),
    .pend    (pend_q),
    .mode    (mode_q),
    .gmask   (mask_q[NSRC]),
    .irq     (irq),
    .fiq     (fiq),
    .svc     (svc_vec),
    .hold    (svc_state == vic_pkg::SVC_HOLD),
    .iclr_wr (iclr_wr)
);

// File: tb/vic_core_bench.sv
module vic_core_bench;
    localparam int  NSRC   = 26;
    localparam int  IW     = 5;
    localparam real CLK_NS = 5.0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_req = '0;
    logic            reg_wr = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NSRC-1:0] irq_cand;
    logic            win_valid;
    logic [IW-1:0]   win_idx;
    logic            vec_fetch = 1'b0;
    logic [31:0]     mem_rdata = 32'hE59F_F000;
    logic [31:0]     instr_rdata;
    logic            irq;
    logic            fiq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    vic_core u_vic_core (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_cand(irq_cand), .win_valid(win_valid), .win_idx(win_idx),
        .vec_fetch(vec_fetch), .mem_rdata(mem_rdata), .instr_rdata(instr_rdata),
        .irq(irq), .fiq(fiq)
    );

    // Bench-side arbiter: lowest index wins
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = NSRC-1; i >= 0; i--) begin
            if (irq_cand[i]) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
            end
        end
    end

    function automatic logic [31:0] exp_op(input int idx);
        logic [31:0] slot;
        slot = 32'h20 + 32'(idx / 6) * 32'h20 + 32'(idx % 6) * 32'h4;
        return 32'hEA00_0000 + ((slot - 32'h20) >> 2);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [NSRC-1:0] v);
        @(negedge clk);
        src_req = v;
        @(negedge clk);
        src_req = '0;
    endtask

    task automatic fetch_chk(input string tag, input logic [31:0] exp);
        @(negedge clk);
        vec_fetch = 1'b1;
        #1;
        chk(tag, instr_rdata, exp);
        @(negedge clk);
        vec_fetch = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        #1;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 fiq", {31'd0, fiq}, 32'd0);
        rd(3'd0, d); chk("R1 ctrl", d, 32'd0);
        rd(3'd1, d); chk("R1 pend", d, 32'd0);
        rd(3'd3, d); chk("R1 mask", d, 32'h07FF_FFFF);
        rd(3'd4, d); chk("R1 svc", d, 32'd0);
    endtask

    task automatic t_pend_clear();
        logic [31:0] d;
        pulse(26'(1) << 3);
        rd(3'd1, d); chk("R2 masked source latches", d, 32'h8);
        chk("R4 masked gives no irq", {31'd0, irq}, 32'd0);
        wr(3'd1, 32'd0);
        rd(3'd1, d); chk("R6 pend write ignored", d, 32'h8);
        wr(3'd5, 32'd0);
        rd(3'd1, d); chk("R5 zero write no effect", d, 32'h8);
        // request and clear in the same cycle
        @(negedge clk);
        src_req = 26'(1) << 3; reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h8;
        @(negedge clk);
        src_req = '0; reg_wr = 1'b0;
        rd(3'd1, d); chk("R5 request beats clear", d, 32'h8);
        rd(3'd5, d); chk("R5 iclr reads zero", d, 32'd0);
        wr(3'd6, 32'h8);
        rd(3'd1, d); chk("R5 fclr clears", d, 32'd0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr(3'd2, 32'h80);
        wr(3'd3, 32'd0);
        pulse(26'(1) << 5);
        #1; chk("R4 irq gated by enable", {31'd0, irq}, 32'd0);
        wr(3'd0, 32'h6);
        #1; chk("R4 irq asserted", {31'd0, irq}, 32'd1);
        chk("R4 fiq idle", {31'd0, fiq}, 32'd0);
        pulse(26'(1) << 7);
        #1; chk("R4 fiq asserted", {31'd0, fiq}, 32'd1);
        chk("R8 fast source not candidate", 32'(irq_cand), 32'h20);
        wr(3'd6, 32'h80);
        #1; chk("R5 fiq cleared", {31'd0, fiq}, 32'd0);
        chk("R4 irq kept", {31'd0, irq}, 32'd1);
        wr(3'd5, 32'h20);
        #1; chk("R5 irq cleared", {31'd0, irq}, 32'd0);
        wr(3'd2, 32'd0);
    endtask

    task automatic t_global();
        logic [31:0] d;
        wr(3'd3, 32'h0400_0000);
        pulse(26'(1) << 5);
        rd(3'd1, d); chk("R3 pend latches under global mask", d, 32'h20);
        chk("R3 irq blocked", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'd0);
        #1; chk("R3 irq after global unmask", {31'd0, irq}, 32'd1);
        wr(3'd5, 32'h20);
    endtask

    task automatic t_vector();
        logic [31:0] d;
        wr(3'd0, 32'h7);
        #1; chk("R7 no fetch passes memory", instr_rdata, mem_rdata);
        pulse(26'(1) << 12);
        rd(3'd4, d); chk("R9 idle svc follows winner", d, 32'h1000);
        fetch_chk("R7 branch for source 12", exp_op(12));
        pulse(26'(1));
        rd(3'd4, d); chk("R9 svc frozen", d, 32'h1000);
        fetch_chk("R10 hold fetch passes memory", mem_rdata);
        wr(3'd5, 32'h1000);
        rd(3'd4, d); chk("R9 released svc", d, 32'h1);
        fetch_chk("R7 branch for source 0", exp_op(0));
        wr(3'd5, 32'h1);
        rd(3'd4, d); chk("R9 svc empty", d, 32'd0);
        pulse(26'(1) << 25);
        fetch_chk("R7 branch for source 25", exp_op(25));
        wr(3'd5, 32'h0200_0000);
        pulse(26'(1) << 7);
        fetch_chk("R7 branch for source 7", exp_op(7));
        wr(3'd5, 32'h80);
        wr(3'd0, 32'h6);
        pulse(26'(1) << 12);
        fetch_chk("R7 vector disabled passes memory", mem_rdata);
        wr(3'd5, 32'h1000);
        rd(3'd1, d); chk("R5 all cleared", d, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pend_clear();
        t_route();
        t_global();
        t_vector();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule